// File: doc/BRIEF.md
# Subtractive GCD Processor

This block is a single-purpose processor that finds the greatest common divisor of two unsigned operands by repeated subtraction. It is split into a datapath and a controller. The datapath holds three parallel-load registers, two subtractors, a less-than comparator and an inequality comparator. The controller is a small state machine. It sees only three Boolean status bits from the datapath, and it drives named load and source-select lines back into the datapath.

A caller places the two operands on `x_i` and `y_i` and raises `go_i` for one cycle while the block is idle. The operands are captured in one cycle. Each pass through the loop then costs one compare cycle and one subtract cycle, and each pass rewrites only the register that held the larger value. When the two working registers match, the value is copied into the result register and `done_o` pulses. A zero operand ends the run at once, with the other operand as the result, so the loop can never spin forever.

Top module: `gcd_proc`

## Requirements
- R1: While reset is held and after it is released with no start request, `d_o` is 0 and `done_o` is 0.
- R2: Operands 12 and 8 give a result of 4, and operands 13 and 5 give a result of 1.
- R3: For any two non-zero operands, the value on `d_o` while `done_o` is high equals their greatest common divisor.
- R4: `done_o` is high for exactly one cycle per run. Let S be the number of subtractions that repeated subtraction needs (0 when the operands are equal or one of them is zero). Then `done_o` is high after the (2·S+1)-th rising edge that follows the edge sampling `go_i`.
- R5: `d_o` changes only on the edge that raises `done_o`, and it then holds its value until the next completion.
- R6: A `go_i` pulse, or any change on `x_i`/`y_i`, during a computation has no effect on that computation's result or timing.
- R7: When one operand is zero, the result is the other operand (0 when both are zero) and S is 0.
- R8: Equal non-zero operands give that same value as the result, with S equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start request, sampled only while idle |
| x_i | input | W (8) | First operand |
| y_i | input | W (8) | Second operand |
| d_o | output | W (8) | Result register output |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each run has a fixed latency. After the edge that samples `go_i`, the result and `done_o` are due on rising edge 2·S+1, where the bench computes S with its own subtraction-count function and takes the expected value from a Euclid model. The bench drives inputs and samples outputs on falling edges and counts falling edges until `done_o` appears. It then compares that count with 2·S+1, checks on the very next falling edge that the pulse has dropped, and checks over the following cycles that `d_o` has not moved.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_SUB  = 2'd2,
        ST_FIN  = 2'd3
    } gcd_state_e;

    typedef enum logic {
        SRC_PORT = 1'b0,
        SRC_DIFF = 1'b1
    } gcd_src_e;

    // Control lines from controller into the datapath
    typedef struct packed {
        logic     x_ld;
        logic     y_ld;
        gcd_src_e x_src;
        gcd_src_e y_src;
        logic     d_ld;
    } gcd_ctrl_t;

    // Status bits from the datapath into the controller
    typedef struct packed {
        logic ne;
        logic lt;
        logic zero;
    } gcd_stat_t;

endpackage

// File: rtl/gcd_reg.sv
module gcd_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= din;
    end
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  gcd_ctrl_t    ctl,
    output gcd_stat_t    stat,
    output logic [W-1:0] x_q,
    output logic [W-1:0] y_q,
    output logic [W-1:0] d_q
);
    logic [W-1:0] diff_xy, diff_yx;
    logic [W-1:0] x_nxt, y_nxt, d_nxt;

    // Two subtractors
    assign diff_xy = x_q - y_q;
    assign diff_yx = y_q - x_q;

    // Source-select multiplexers
    assign x_nxt = (ctl.x_src == SRC_PORT) ? x_i : diff_xy;
    assign y_nxt = (ctl.y_src == SRC_PORT) ? y_i : diff_yx;

    // Result source: a zero x register hands over the other operand
    assign d_nxt = (x_q == '0) ? y_q : x_q;

    // Comparators
    assign stat.ne   = (x_q != y_q);
    assign stat.lt   = (x_q <  y_q);
    assign stat.zero = (x_q == '0) || (y_q == '0);

    gcd_reg #(.W(W)) u_xreg (.clk(clk), .rst(rst), .ld(ctl.x_ld), .din(x_nxt), .q(x_q));
    gcd_reg #(.W(W)) u_yreg (.clk(clk), .rst(rst), .ld(ctl.y_ld), .din(y_nxt), .q(y_q));
    gcd_reg #(.W(W)) u_dreg (.clk(clk), .rst(rst), .ld(ctl.d_ld), .din(d_nxt), .q(d_q));
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  gcd_stat_t  stat,
    output gcd_ctrl_t  ctl,
    output gcd_state_e state,
    output logic       done_o
);
    gcd_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        ctl       = '0;
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go_i) begin
                    ctl.x_ld  = 1'b1;
                    ctl.y_ld  = 1'b1;
                    ctl.x_src = SRC_PORT;
                    ctl.y_src = SRC_PORT;
                    state_nxt = ST_CMP;
                end
            end
            ST_CMP: begin
                if (stat.zero || !stat.ne) begin
                    ctl.d_ld  = 1'b1;
                    state_nxt = ST_FIN;
                end else begin
                    state_nxt = ST_SUB;
                end
            end
            ST_SUB: begin
                if (stat.lt) begin
                    ctl.y_ld  = 1'b1;
                    ctl.y_src = SRC_DIFF;
                end else begin
                    ctl.x_ld  = 1'b1;
                    ctl.x_src = SRC_DIFF;
                end
                state_nxt = ST_CMP;
            end
            ST_FIN: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign done_o = (state == ST_FIN);
endmodule

// File: rtl/gcd_proc.sv
module gcd_proc
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] d_o,
    output logic         done_o
);
    gcd_ctrl_t    ctl;
    gcd_stat_t    stat;
    gcd_state_e   state;
    logic [W-1:0] x_q, y_q;

    gcd_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .go_i  (go_i),
        .stat  (stat),
        .ctl   (ctl),
        .state (state),
        .done_o(done_o)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk (clk),
        .rst (rst),
        .x_i (x_i),
        .y_i (y_i),
        .ctl (ctl),
        .stat(stat),
        .x_q (x_q),
        .y_q (y_q),
        .d_q (d_o)
    );
endmodule

// File: rtl/gcd_proc_chk.sv
module gcd_proc_chk
    import gcd_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         done_o,
    input logic [W-1:0] d_o,
    input logic [W-1:0] x_q,
    input logic [W-1:0] y_q,
    input gcd_ctrl_t    ctl,
    input gcd_stat_t    stat
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

    AST_ONE_REG_PER_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.x_ld && ctl.y_ld) |-> (ctl.x_src == SRC_PORT && ctl.y_src == SRC_PORT)); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(d_o)); // R5

    AST_SUB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ctl.x_ld && ctl.x_src == SRC_DIFF) |-> (stat.ne && !stat.lt && !stat.zero)); // R3

    AST_FIN_CONVERGED: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (stat.zero || x_q == y_q)); // R3

    AST_FIN_VALUE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (d_o == ((x_q == '0) ? y_q : x_q))); // R7
endmodule

bind gcd_proc gcd_proc_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .done_o(done_o),
    .d_o   (d_o),
    .x_q   (x_q),
    .y_q   (y_q),
    .ctl   (ctl),
    .stat  (stat)
);

// File: tb/gcd_proc_test.sv
module gcd_proc_test;
    localparam int W   = 8;
    localparam int LIM = 4 * (1 << W) + 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go_i = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [W-1:0] d_o;
    logic         done_o;

    int n_chk = 0;
    int n_bad = 0;

    gcd_proc #(.W(W)) uut (
        .clk(clk), .rst(rst), .go_i(go_i),
        .x_i(x_i), .y_i(y_i), .d_o(d_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    function automatic int gcd_ref(int a, int b);
        int t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int steps_ref(int a, int b);
        int n = 0;
        if (a == 0 || b == 0) return 0;
        while (a != b) begin
            if (a < b) b = b - a; else a = a - b;
            n++;
        end
        return n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(int a, int b, string tag, bit inject);
        int cyc = 0;
        int exp_d = gcd_ref(a, b);
        int exp_c = 2 * steps_ref(a, b) + 1;
        logic [W-1:0] held;
        @(negedge clk);
        x_i = a[W-1:0]; y_i = b[W-1:0]; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        x_i = '1; y_i = '1;   // ports disturbed after capture (R6)
        while (!done_o && cyc < LIM) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 2) begin
                go_i = 1'b1; x_i = 8'd13; y_i = 8'd5;
            end else if (inject && cyc == 3) begin
                go_i = 1'b0;
            end
        end
        go_i = 1'b0;
        check(done_o === 1'b1, {tag, " done seen"}, int'(done_o), 1);
        check(d_o == exp_d[W-1:0], {tag, " result"}, int'(d_o), exp_d);
        check(cyc == exp_c, {tag, " R4 latency"}, cyc, exp_c);
        held = d_o;
        @(negedge clk);
        check(done_o === 1'b0, {tag, " R4 pulse width"}, int'(done_o), 0);
        repeat (3) @(negedge clk);
        check(d_o == held, {tag, " R5 hold"}, int'(d_o), int'(held));
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int a, b;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(d_o == '0, "R1 reset result", int'(d_o), 0);
        check(done_o === 1'b0, "R1 reset done", int'(done_o), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(done_o === 1'b0 && d_o == '0, "R1 idle after reset", int'(d_o), 0);

        run(12, 8, "R2 12/8", 1'b0);
        run(13, 5, "R2 13/5", 1'b0);
        run(12, 8, "R6 go during run", 1'b1);
        run(0, 9, "R7 x zero", 1'b0);
        run(21, 0, "R7 y zero", 1'b0);
        run(0, 0, "R7 both zero", 1'b0);
        run(77, 77, "R8 equal", 1'b0);
        run(255, 1, "R3 max/one", 1'b0);
        run(1, 255, "R3 one/max", 1'b0);
        run(255, 254, "R3 adjacent", 1'b0);

        for (int i = 0; i < 150; i++) begin
            a = int'($urandom % 255) + 1;
            b = int'($urandom % 255) + 1;
            run(a, b, "R3 random", 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule